// File: doc/BRIEF.md
# Smart-Card T=0 Character Receiver

This block receives asynchronous half-duplex characters of the T=0 kind from a single shared I/O line. A character opens with a low start bit. Eight data bits follow, least significant first, then one parity bit chosen so that the count of ones across data and parity is even, then a guard interval. The line is sensed through a two-flop synchronizer. A free-running oversampling tick (`OVS` ticks per bit) times every bit. Each bit is sampled at its midpoint, counted from the detected falling edge of the start bit.

When the parity check fails and the NACK-inhibit mode input is low, the block pulls the line low for exactly one bit time, starting at the end of the parity bit. It then waits out the normal guard interval, so an errored character lasts one bit longer than a clean one. The output `line_pull_low` is the pad's drive-low enable. Characters that are accepted land in a holding register with a ready flag. A rejected character sets a sticky parity-error flag and leaves the holding register untouched. When NACK-inhibit is set, an errored character is silently accepted as if it were clean. Every parity failure counts into an 8-bit saturating counter that is cleared by a read strobe.

The controller is a state machine with six states. IDLE waits for a falling edge. START confirms the start bit at mid-bit and drops back to IDLE if the line is high again, which rejects a glitch. DATA shifts in eight bits. PARITY samples the parity bit and, at the end of the bit, commits the result. From PARITY the machine goes to NACK on a reported error, or to GUARD otherwise. NACK drives the line low for one bit and then moves to GUARD. GUARD ignores the line for `GUARD_BITS` bit times and then returns to IDLE.

Top module: `sc_t0_rx`

## Requirements
- R1: After reset, `hold_valid`, `perr_flag` and `line_pull_low` are 0, and both `hold_data` and `errcnt` are 0.
- R2: A character whose parity bit makes the total count of ones over D0..D7 and parity even is written to `hold_data`, with bit 0 being the first data bit received. `hold_valid` is set at the end of the parity bit.
- R3: With `inhibit_nack` low, a parity failure asserts `line_pull_low` for exactly `OVS` oversampling ticks, beginning at the end of the parity bit. The same failure sets `perr_flag`, and `hold_data` and `hold_valid` keep their values.
- R4: With `inhibit_nack` high, a parity failure never asserts `line_pull_low`. The character is stored, `hold_valid` is set, and `perr_flag` is not set.
- R5: Each parity failure increments `errcnt`, whether or not NACK is inhibited. The count stops at 255 and never wraps.
- R6: A one-cycle `errcnt_rd` pulse clears `errcnt` to 0 on the next clock. If an error is counted in that same cycle, the new value is 1.
- R7: A one-cycle `hold_rd` pulse clears `hold_valid`, unless a character is stored in that same cycle.
- R8: A one-cycle `perr_clr` pulse (write-one-to-clear) clears `perr_flag`, unless a new NACKed error arrives in that same cycle.
- R9: A low pulse shorter than half a bit time is rejected at the mid-point of the start bit. No character is stored and nothing is counted.
- R10: `line_pull_low` is never asserted while a clean character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick, one clock wide, `OVS` per bit |
| line_in | input | 1 | Sensed level of the shared I/O line |
| inhibit_nack | input | 1 | Mode: suppress NACK and accept errored characters |
| hold_rd | input | 1 | Read strobe for the holding register, clears ready |
| perr_clr | input | 1 | Write-one-to-clear strobe for the parity-error flag |
| errcnt_rd | input | 1 | Read strobe for the error counter, clears it |
| line_pull_low | output | 1 | Pad drive-low enable (NACK) |
| hold_data | output | 8 | Holding register |
| hold_valid | output | 1 | Ready flag |
| perr_flag | output | 1 | Sticky parity-error flag |
| errcnt | output | 8 | Saturating parity-error count |

## Verification
The assertions assume that `inhibit_nack` stays fixed for the whole of a character, from start bit to the end of guard. They also assume the read and clear strobes are single-cycle pulses, and that the line is released by the far end while the block drives NACK. The stimulus models the line as a wired-AND of the bench driver and `line_pull_low`. It changes mode only between characters, and it begins each new character only after the longest possible frame (parity, NACK and guard) has elapsed. Strobes are issued at quiet moments, so the same-cycle priority cases are covered by the assertions rather than by directed checks.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_NACK,
        ST_GUARD
    } rx_state_t;
endpackage

// File: rtl/sc_t0_linesync.sv
module sc_t0_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= line_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign line_s = chain[STAGES-1];
    assign fall   = prev & ~chain[STAGES-1];
endmodule

// File: rtl/sc_t0_bittimer.sv
module sc_t0_bittimer #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic mid,
    output logic bit_end
);
    localparam int TW   = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int HALF = OVS / 2;

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == TW'(OVS - 1)) cnt <= '0;
            else                     cnt <= cnt + 1'b1;
        end
    end

    assign mid     = tick && !restart && (cnt == TW'(HALF - 1));
    assign bit_end = tick && !restart && (cnt == TW'(OVS - 1));
endmodule

// File: rtl/sc_t0_errcount.sv
module sc_t0_errcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= inc ? CNT_W'(1) : '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sc_t0_rx.sv
module sc_t0_rx #(
    parameter int OVS        = 16,
    parameter int DATA_W     = 8,
    parameter int GUARD_BITS = 2,
    parameter int CNT_W      = 8,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              line_in,
    input  logic              inhibit_nack,
    input  logic              hold_rd,
    input  logic              perr_clr,
    input  logic              errcnt_rd,
    output logic              line_pull_low,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_valid,
    output logic              perr_flag,
    output logic [CNT_W-1:0]  errcnt
);
    import sc_t0_pkg::*;

    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int GW = (GUARD_BITS > 1) ? $clog2(GUARD_BITS) : 1;

    rx_state_t         state, state_nx;
    logic              line_s, fall;
    logic              mid, bit_end, restart;
    logic [DATA_W-1:0] shreg;
    logic [BW-1:0]     bit_idx;
    logic [GW-1:0]     guard_idx;
    logic              par_bit;
    logic              par_bad;
    logic              commit, commit_store, commit_err, err_inc;

    sc_t0_linesync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .line_s (line_s),
        .fall   (fall)
    );

    sc_t0_bittimer #(.OVS(OVS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (os_tick),
        .restart(restart),
        .mid    (mid),
        .bit_end(bit_end)
    );

    sc_t0_errcount #(.CNT_W(CNT_W)) u_errcnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (err_inc),
        .clr  (errcnt_rd),
        .count(errcnt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (fall) state_nx = ST_START;
            ST_START: begin
                if (mid && line_s) state_nx = ST_IDLE;
                else if (bit_end)  state_nx = ST_DATA;
            end
            ST_DATA:   if (bit_end && bit_idx == BW'(DATA_W - 1)) state_nx = ST_PARITY;
            ST_PARITY: if (bit_end) state_nx = (par_bad && !inhibit_nack) ? ST_NACK : ST_GUARD;
            ST_NACK:   if (bit_end) state_nx = ST_GUARD;
            ST_GUARD:  if (bit_end && guard_idx == GW'(GUARD_BITS - 1)) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs and commit decode
    always_comb begin
        line_pull_low = (state == ST_NACK);
        restart       = (state == ST_IDLE) && fall;
        commit        = (state == ST_PARITY) && bit_end;
        par_bad       = ^{shreg, par_bit};
        commit_store  = commit && (!par_bad || inhibit_nack);
        commit_err    = commit && par_bad && !inhibit_nack;
        err_inc       = commit && par_bad;
    end

    // receive datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_idx   <= '0;
            guard_idx <= '0;
            par_bit   <= 1'b0;
        end else begin
            if (state == ST_START && bit_end) bit_idx <= '0;
            if (state == ST_DATA) begin
                if (mid)     shreg   <= {line_s, shreg[DATA_W-1:1]};
                if (bit_end) bit_idx <= bit_idx + 1'b1;
            end
            if (state == ST_PARITY && mid) par_bit <= line_s;
            if (state != ST_GUARD)         guard_idx <= '0;
            else if (bit_end)              guard_idx <= guard_idx + 1'b1;
        end
    end

    // holding register and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data  <= '0;
            hold_valid <= 1'b0;
            perr_flag  <= 1'b0;
        end else begin
            if (commit_store) begin
                hold_data  <= shreg;
                hold_valid <= 1'b1;
            end else if (hold_rd) begin
                hold_valid <= 1'b0;
            end
            if (commit_err)    perr_flag <= 1'b1;
            else if (perr_clr) perr_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_t0_rx_chk.sv
module sc_t0_rx_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inhibit_nack,
    input logic             hold_rd,
    input logic             perr_clr,
    input logic             errcnt_rd,
    input logic             line_pull_low,
    input logic             hold_valid,
    input logic             perr_flag,
    input logic [CNT_W-1:0] errcnt,
    input logic             commit_store,
    input logic             commit_err
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    AST_NACK_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull_low |-> perr_flag || perr_clr || $past(perr_clr)); // R3
    AST_INHIBIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_nack && !line_pull_low) |=> !line_pull_low); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (errcnt == TOP && !errcnt_rd) |=> errcnt == TOP); // R5
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        errcnt_rd |=> errcnt <= CNT_W'(1)); // R6
    AST_READY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_rd && !commit_store) |=> !hold_valid); // R7
    AST_PERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_clr && !commit_err) |=> !perr_flag); // R8
endmodule

bind sc_t0_rx sc_t0_rx_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .inhibit_nack (inhibit_nack),
    .hold_rd      (hold_rd),
    .perr_clr     (perr_clr),
    .errcnt_rd    (errcnt_rd),
    .line_pull_low(line_pull_low),
    .hold_valid   (hold_valid),
    .perr_flag    (perr_flag),
    .errcnt       (errcnt),
    .commit_store (commit_store),
    .commit_err   (commit_err)
);

// File: tb/sc_t0_rx_bench.sv
module sc_t0_rx_bench;
    localparam int OVS     = 8;
    localparam int BIT_CLK = OVS * 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       tph = 1'b0;
    logic       drv_line = 1'b1;
    logic       inhibit_nack = 1'b0;
    logic       hold_rd = 1'b0;
    logic       perr_clr = 1'b0;
    logic       errcnt_rd = 1'b0;
    logic       line_pull_low;
    logic [7:0] hold_data;
    logic       hold_valid;
    logic       perr_flag;
    logic [7:0] errcnt;
    logic       line_in;
    int         checks = 0;
    int         errors = 0;
    int         nack_cyc = 0;
    bit         done = 0;

    assign line_in = drv_line & ~line_pull_low;

    sc_t0_rx #(.OVS(OVS)) u_sc_t0_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_in(line_in),
        .inhibit_nack(inhibit_nack), .hold_rd(hold_rd), .perr_clr(perr_clr),
        .errcnt_rd(errcnt_rd), .line_pull_low(line_pull_low),
        .hold_data(hold_data), .hold_valid(hold_valid), .perr_flag(perr_flag),
        .errcnt(errcnt)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tph     <= ~tph;
        os_tick <= tph;
        if (line_pull_low) nack_cyc <= nack_cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad);
        @(negedge clk);
        nack_cyc = 0;
        drv_line = 1'b0;
        wait_bits(1);
        for (int i = 0; i < 8; i++) begin
            drv_line = d[i];
            wait_bits(1);
        end
        drv_line = (^d) ^ bad;
        wait_bits(1);
        drv_line = 1'b1;
        wait_bits(4);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        if (which == 0) hold_rd = 1'b1;
        else if (which == 1) perr_clr = 1'b1;
        else errcnt_rd = 1'b1;
        @(negedge clk);
        hold_rd = 1'b0; perr_clr = 1'b0; errcnt_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 hold_valid", hold_valid, 0);
        chk("R1 perr_flag", perr_flag, 0);
        chk("R1 line_pull_low", line_pull_low, 0);
        chk("R1 hold_data", hold_data, 0);
        chk("R1 errcnt", errcnt, 0);
    endtask

    task automatic t_clean();
        send_frame(8'hA5, 1'b0);
        chk("R2 data A5", hold_data, 8'hA5);
        chk("R2 ready", hold_valid, 1);
        chk("R10 no nack", nack_cyc, 0);
        chk("R2 errcnt", errcnt, 0);
        strobe(0);
        chk("R7 ready cleared", hold_valid, 0);
        send_frame(8'h01, 1'b0);
        chk("R2 data 01", hold_data, 8'h01);
        chk("R10 no nack odd", nack_cyc, 0);
        strobe(0);
    endtask

    task automatic t_nack();
        send_frame(8'h3C, 1'b1);
        chk("R3 nack width", nack_cyc, BIT_CLK);
        chk("R3 data kept", hold_data, 8'h01);
        chk("R3 ready kept", hold_valid, 0);
        chk("R3 perr set", perr_flag, 1);
        chk("R5 errcnt one", errcnt, 1);
        strobe(1);
        chk("R8 perr cleared", perr_flag, 0);
    endtask

    task automatic t_inhibit();
        inhibit_nack = 1'b1;
        send_frame(8'h7E, 1'b1);
        chk("R4 no nack", nack_cyc, 0);
        chk("R4 data stored", hold_data, 8'h7E);
        chk("R4 ready", hold_valid, 1);
        chk("R4 perr clear", perr_flag, 0);
        chk("R5 errcnt two", errcnt, 2);
        strobe(2);
        chk("R6 errcnt cleared", errcnt, 0);
        strobe(0);
        inhibit_nack = 1'b0;
    endtask

    task automatic t_glitch();
        @(negedge clk);
        drv_line = 1'b0;
        repeat (4) @(negedge clk);
        drv_line = 1'b1;
        wait_bits(12);
        chk("R9 no ready", hold_valid, 0);
        chk("R9 data kept", hold_data, 8'h7E);
        chk("R9 no count", errcnt, 0);
    endtask

    task automatic t_saturate();
        inhibit_nack = 1'b1;
        for (int k = 0; k < 258; k++) send_frame(8'(k), 1'b1);
        chk("R5 saturate 255", errcnt, 255);
        strobe(2);
        chk("R6 clear after sat", errcnt, 0);
        inhibit_nack = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_clean();
        t_nack();
        t_inhibit();
        t_glitch();
        t_saturate();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule